// File: doc/BRIEF.md
# Four-Lane Serial Master Transmitter

This block sends data words to a slave over four data lanes, four bits per serial clock cycle. Software or a DMA engine writes each word into a transmit data register. The word waits in a one-word buffer until the shifter can take it. The shifter drives the word most-significant nibble first, nibble by nibble. It generates the serial clock from the system clock through a programmable half-period divider, and the serial clock rests low between words. A word that is waiting when the current word ends is taken at that boundary with no idle gap. Software drives the slave-select output directly through a control bit.

Two flags report progress. The buffer-empty flag shows that the data register can accept a word. The transfer-end flag shows that the last word has shifted out and nothing is waiting. The interrupt output combines each flag with its own enable. Each DMA channel has an enable bit, and an enabled channel requests a word while the buffer is empty.

The shifter is a three-state machine. IDLE holds the clock low and the lanes at zero. LOW drives the current nibble with the clock low. HIGH holds the nibble with the clock high.
- IDLE to LOW (start): the buffer holds a word, the engine is enabled and the lanes are outputs.
- LOW to HIGH (rise): the low half-period has elapsed.
- HIGH to LOW (next nibble): the high half-period has elapsed and nibbles remain.
- HIGH to LOW (chain): the high half-period has elapsed, the last nibble is done and a new word is waiting.
- HIGH to IDLE (finish): the high half-period has elapsed, the last nibble is done and the buffer is empty.

Top module: `qspi_tx_engine`

## Requirements
- R1: After reset, the registers read as follows. The buffer-empty flag is 1 and the transfer-end flag is 0. Slave select is high (negated). The serial clock is low and the lanes are zero. The control register reads 0x0004 and the mode register reads 0.
- R2: The register map is:
  - Address 0 is control. Bit 0 is enable. Bit 1 is direction. Bit 2 is slave select. Bit 8 is the buffer-empty interrupt enable. Bit 9 is the transfer-end interrupt enable. Bit 12+c is the DMA enable for channel c.
  - Address 1 is mode. Bits [3:0] hold the nibble count minus one. Bits [15:8] hold the half-period in system clocks.
  - Address 2 is flags. Bit 0 is buffer-empty and is read-only. Bit 1 is transfer-end.
  - Address 3 is transmit data. It is write-only and reads 0.
  - Bits that are not defined read 0.
- R3: When direction is 0, all four lane output enables are 1. When direction is 1, the enables are 0 and no word starts.
- R4: The slave-select output equals control bit 2. Writing 0 asserts it (low) and writing 1 negates it.
- R5: A write to the data register clears buffer-empty in the next cycle. Buffer-empty sets again in the cycle after the shifter takes the word.
- R6: A word is sent as its low N nibbles, highest nibble first. N is the nibble-count field plus one, capped at 4.
- R7: Each nibble is driven for 2H system clocks. The serial clock is low for the first H clocks and high for the last H clocks. H is the half-period field, and a field of 0 counts as 1. The first nibble appears in the second cycle after the data write.
- R8: When a word is waiting as the last nibble's high phase ends, its first nibble follows at once with no idle cycle.
- R9: Transfer-end sets when the last nibble's high phase ends with no word waiting. Writing 1 to flag bit 1 clears it. Writing 0 has no effect. A set in the same cycle as a clear wins.
- R10: The interrupt output is (buffer-empty AND bit 8) OR (transfer-end AND bit 9).
- R11: DMA request c is high when its enable is 1 and buffer-empty is 1. It drops in the same cycle that the data register is written.
- R12: The lanes hold steady while the serial clock is high, and the serial clock stays low in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Read data for reg_addr |
| sclk | output | 1 | Serial clock |
| sdio_o | output | 4 | Data lanes 3..0 |
| sdio_oe | output | 4 | Lane output enables |
| ss_n | output | 1 | Slave select, active low |
| irq | output | 1 | Interrupt request |
| dma_req | output | NCH | DMA request per channel |

## Verification
A register write takes effect one cycle after its strobe is sampled. Buffer-empty, transfer-end and slave select therefore change in the cycle after the write. A DMA request drops combinationally in the write cycle itself. A word starts in the cycle after the buffer fills. Each nibble then lasts exactly 2H cycles, and a chained word follows in the cycle after the previous high phase ends.

The bench applies inputs shortly after each rising edge. A behavioural model, built on a nibble queue and phase counters, steps on the same edge. Every output and the read data are compared with the model at the falling edge. Each result is therefore checked in exactly the cycle it falls due, never a cycle early or late.

// File: rtl/qspi_tx_pkg.sv
package qspi_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } shift_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;
    localparam logic [1:0] ADDR_TXD  = 2'd3;

    localparam int CTRL_EN       = 0;
    localparam int CTRL_DIR      = 1;
    localparam int CTRL_SS       = 2;
    localparam int CTRL_IE_TBE   = 8;
    localparam int CTRL_IE_TEND  = 9;
    localparam int CTRL_DMA_LSB  = 12;

    localparam int FLAG_TBE  = 0;
    localparam int FLAG_TEND = 1;

    localparam int LANES = 4;

endpackage

// File: rtl/qspi_tx_regs.sv
module qspi_tx_regs
    import qspi_tx_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int NCH     = 2,
    parameter int NIB_MAX = WORD_W / LANES,
    parameter int NCW     = $clog2(NIB_MAX + 1),
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              load,
    input  logic              done,
    output logic              buf_full,
    output logic [WORD_W-1:0] buf_data,
    output logic              start_ok,
    output logic [NCW-1:0]    nibbles,
    output logic [DIV_W-1:0]  half,
    output logic              dir,
    output logic              ss_n,
    output logic              irq,
    output logic [NCH-1:0]    dma_req
);

    localparam logic [WORD_W-1:0] CTRL_MASK =
        WORD_W'((1 << CTRL_EN) | (1 << CTRL_DIR) | (1 << CTRL_SS) |
                (1 << CTRL_IE_TBE) | (1 << CTRL_IE_TEND)) |
        (WORD_W'((1 << NCH) - 1) << CTRL_DMA_LSB);
    localparam logic [WORD_W-1:0] MODE_MASK = WORD_W'(16'hFF0F);
    localparam logic [WORD_W-1:0] CTRL_RST  = WORD_W'(1 << CTRL_SS);

    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] mode_q;
    logic [WORD_W-1:0] buf_q;
    logic              full_q;
    logic              tend_q;
    logic              wr_ctrl, wr_mode, wr_flag, wr_txd;
    logic              tbe;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);
    assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
    assign wr_txd  = reg_wr && (reg_addr == ADDR_TXD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mode_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
            if (wr_mode) mode_q <= reg_wdata & MODE_MASK;
        end
    end

    // one-word transmit buffer; a software write wins over a shifter load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            buf_q  <= '0;
        end else if (wr_txd) begin
            full_q <= 1'b1;
            buf_q  <= reg_wdata;
        end else if (load) begin
            full_q <= 1'b0;
        end
    end

    // transfer-end: set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                              tend_q <= 1'b0;
        else if (done)                           tend_q <= 1'b1;
        else if (wr_flag && reg_wdata[FLAG_TEND]) tend_q <= 1'b0;
    end

    assign tbe = ~full_q;

    always_comb begin
        if (int'(mode_q[3:0]) >= NIB_MAX) nibbles = NCW'(NIB_MAX);
        else                              nibbles = NCW'(int'(mode_q[3:0]) + 1);
        half = (mode_q[15:8] == '0) ? DIV_W'(1) : DIV_W'(mode_q[15:8]);
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_MODE: reg_rdata = mode_q;
            ADDR_FLAG: begin
                reg_rdata            = '0;
                reg_rdata[FLAG_TBE]  = tbe;
                reg_rdata[FLAG_TEND] = tend_q;
            end
            default:   reg_rdata = '0;
        endcase
    end

    assign buf_full = full_q;
    assign buf_data = buf_q;
    assign start_ok = ctrl_q[CTRL_EN] & ~ctrl_q[CTRL_DIR];
    assign dir      = ctrl_q[CTRL_DIR];
    assign ss_n     = ctrl_q[CTRL_SS];
    assign irq      = (tbe & ctrl_q[CTRL_IE_TBE]) | (tend_q & ctrl_q[CTRL_IE_TEND]);

    for (genvar c = 0; c < NCH; c++) begin : g_dma
        assign dma_req[c] = ctrl_q[CTRL_DMA_LSB + c] & tbe & ~wr_txd;
    end

    AST_TBE_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd |=> !tbe); // R5
    AST_TEND_SETS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> tend_q); // R9
    AST_TEND_W0_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !reg_wdata[FLAG_TEND] && tend_q) |=> tend_q); // R9

endmodule

// File: rtl/qspi_tx_shifter.sv
module qspi_tx_shifter
    import qspi_tx_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int NIB_MAX = WORD_W / LANES,
    parameter int NCW     = $clog2(NIB_MAX + 1),
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              buf_full,
    input  logic [WORD_W-1:0] buf_data,
    input  logic [NCW-1:0]    nibbles,
    input  logic [DIV_W-1:0]  half,
    output logic              load,
    output logic              done,
    output logic              sclk,
    output logic [LANES-1:0]  sdio_o
);

    shift_state_e      state_q, state_d;
    logic [DIV_W-1:0]  cnt_q;
    logic [NCW-1:0]    left_q;
    logic [WORD_W-1:0] sh_q;
    logic              phase_end;
    logic              last_nib;
    logic              advance;

    assign phase_end = (cnt_q >= half - DIV_W'(1));
    assign last_nib  = (left_q <= NCW'(1));

    // next-state and handshake decode
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        done    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_full && start_ok) begin
                    load    = 1'b1;
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (phase_end) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (phase_end) begin
                    if (!last_nib) begin
                        advance = 1'b1;
                        state_d = ST_LOW;
                    end else if (buf_full) begin
                        load    = 1'b1;
                        state_d = ST_LOW;
                    end else begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            left_q <= '0;
            sh_q   <= '0;
        end else begin
            if (state_q == ST_IDLE || phase_end) cnt_q <= '0;
            else                                 cnt_q <= cnt_q + DIV_W'(1);
            if (load) begin
                sh_q   <= buf_data << (LANES * (NIB_MAX - int'(nibbles)));
                left_q <= nibbles;
            end else if (advance) begin
                sh_q   <= sh_q << LANES;
                left_q <= left_q - NCW'(1);
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        unique case (state_q)
            ST_LOW: begin
                sclk   = 1'b0;
                sdio_o = sh_q[WORD_W-1 -: LANES];
            end
            ST_HIGH: begin
                sclk   = 1'b1;
                sdio_o = sh_q[WORD_W-1 -: LANES];
            end
            default: begin
                sclk   = 1'b0;
                sdio_o = '0;
            end
        endcase
    end

    AST_LANES_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && $past(state_q == ST_HIGH)) |-> $stable(sdio_o)); // R12
    AST_LOAD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> buf_full); // R5
    AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_ok) |=> state_q == ST_IDLE); // R3
    AST_FINISH_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !sclk); // R12

endmodule

// File: rtl/qspi_tx_engine.sv
module qspi_tx_engine
    import qspi_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NCH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sclk,
    output logic [3:0]        sdio_o,
    output logic [3:0]        sdio_oe,
    output logic              ss_n,
    output logic              irq,
    output logic [NCH-1:0]    dma_req
);

    localparam int NIB_MAX = WORD_W / LANES;
    localparam int NCW     = $clog2(NIB_MAX + 1);
    localparam int DIV_W   = 8;

    logic              load, done, buf_full, start_ok, dir;
    logic [WORD_W-1:0] buf_data;
    logic [NCW-1:0]    nibbles;
    logic [DIV_W-1:0]  half;

    qspi_tx_regs #(
        .WORD_W(WORD_W), .NCH(NCH), .NIB_MAX(NIB_MAX), .NCW(NCW), .DIV_W(DIV_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .load(load), .done(done),
        .buf_full(buf_full), .buf_data(buf_data), .start_ok(start_ok),
        .nibbles(nibbles), .half(half), .dir(dir),
        .ss_n(ss_n), .irq(irq), .dma_req(dma_req)
    );

    qspi_tx_shifter #(
        .WORD_W(WORD_W), .NIB_MAX(NIB_MAX), .NCW(NCW), .DIV_W(DIV_W)
    ) shift_i (
        .clk(clk), .rst_n(rst_n),
        .start_ok(start_ok), .buf_full(buf_full), .buf_data(buf_data),
        .nibbles(nibbles), .half(half),
        .load(load), .done(done), .sclk(sclk), .sdio_o(sdio_o)
    );

    assign sdio_oe = {LANES{~dir}};

    AST_SS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL) |=> (ss_n == $past(reg_wdata[CTRL_SS]))); // R4
    AST_DMA_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TXD) |-> (dma_req == '0)); // R11
    AST_OE_OFF_WHEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && reg_wdata[CTRL_DIR]) |=> (sdio_oe == '0)); // R3

endmodule

// File: tb/qspi_tx_engine_tb.sv
`timescale 1ns/1ps
module qspi_tx_engine_tb_top;

    localparam int W = 16;
    localparam int NCH = 2;
    localparam logic [15:0] CMASK = 16'h3307;
    localparam logic [15:0] MMASK = 16'hFF0F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd2;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          sclk, ss_n, irq;
    logic [3:0]    sdio_o, sdio_oe;
    logic [NCH-1:0] dma_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    qspi_tx_engine #(.WORD_W(W), .NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .ss_n(ss_n), .irq(irq), .dma_req(dma_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctrl, m_mode, m_buf;
    bit          m_full, m_tend;
    int          m_phase;   // 0 idle, 1 clock low, 2 clock high
    int          m_ctr;
    logic [3:0]  m_nq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 16'h0004; m_mode = 0; m_buf = 0;
            m_full = 0; m_tend = 0; m_phase = 0; m_ctr = 0;
            m_nq.delete();
        end else begin
            int h, n;
            bit ld, fin;
            h = (m_mode[15:8] == 0) ? 1 : int'(m_mode[15:8]);
            n = (m_mode[3:0] >= 3) ? 4 : int'(m_mode[3:0]) + 1;
            ld = 0; fin = 0;
            case (m_phase)
                0: if (m_full && m_ctrl[0] && !m_ctrl[1]) ld = 1;
                1: if (m_ctr >= h - 1) begin m_phase = 2; m_ctr = 0; end
                   else m_ctr++;
                2: if (m_ctr >= h - 1) begin
                       void'(m_nq.pop_front());
                       m_ctr = 0;
                       if (m_nq.size() != 0) m_phase = 1;
                       else if (m_full) ld = 1;
                       else begin m_phase = 0; m_tend = 1; fin = 1; end
                   end else m_ctr++;
                default: m_phase = 0;
            endcase
            if (ld) begin
                for (int k = n - 1; k >= 0; k--) m_nq.push_back(m_buf[4*k +: 4]);
                m_full = 0; m_phase = 1; m_ctr = 0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata & CMASK;
                    2'd1: m_mode = reg_wdata & MMASK;
                    2'd2: if (reg_wdata[1] && !fin) m_tend = 0;
                    default: begin m_buf = reg_wdata; m_full = 1; end
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] er;
            logic [NCH-1:0] ed;
            bit tbe;
            tbe = !m_full;
            case (reg_addr)
                2'd0: er = m_ctrl;
                2'd1: er = m_mode;
                2'd2: er = {14'b0, m_tend, tbe};
                default: er = 16'h0;
            endcase
            for (int c = 0; c < NCH; c++)
                ed[c] = m_ctrl[12+c] & tbe & !(reg_wr && reg_addr == 2'd3);
            chk("R7 sclk", 32'(sclk), 32'(m_phase == 2));
            chk("R6 lanes", 32'(sdio_o), 32'((m_phase == 0 || m_nq.size() == 0) ? 4'h0 : m_nq[0]));
            chk("R3 oe", 32'(sdio_oe), 32'(m_ctrl[1] ? 4'h0 : 4'hF));
            chk("R4 ss_n", 32'(ss_n), 32'(m_ctrl[2]));
            chk("R10 irq", 32'(irq), 32'((tbe & m_ctrl[8]) | (m_tend & m_ctrl[9])));
            chk("R11 dma", 32'(dma_req), 32'(ed));
            chk("R2 rdata", 32'(reg_rdata), 32'(er));
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic peek(input logic [1:0] a);
        @(posedge clk); #2; reg_addr = a;
        @(posedge clk); #2; reg_addr = 2'd2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_end();
        for (int i = 0; i < 4000 && !m_tend; i++) @(posedge clk);
        #2;
        chk("R9 end reached", 32'(m_tend), 32'd1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags", 32'(reg_rdata), 32'h1);
        chk("R1 ss_n", 32'(ss_n), 32'd1);
        chk("R1 sclk", 32'(sclk), 32'd0);
        peek(2'd0);
        idle(2);

        // R6 R7 R8: four nibbles, H=1, two words back to back
        bus_wr(2'd1, 16'h0103);
        bus_wr(2'd0, 16'h0301);
        bus_wr(2'd3, 16'hA5C3);
        bus_wr(2'd3, 16'h1234);
        wait_end();
        bus_wr(2'd2, 16'h0000);   // R9 writing 0 leaves the flag
        #2 chk("R9 w0 keeps", 32'(m_tend), 32'd1);
        bus_wr(2'd2, 16'h0002);   // R9 clear
        peek(2'd3);               // R2 data register reads zero

        // two nibbles, H=3
        bus_wr(2'd1, 16'h0301);
        bus_wr(2'd3, 16'h00BE);
        bus_wr(2'd3, 16'hF00D);
        wait_end();
        bus_wr(2'd2, 16'h0002);

        // nibble count clamps at 4, zero half-period acts as 1
        bus_wr(2'd1, 16'h0007);
        bus_wr(2'd3, 16'h9876);
        wait_end();
        bus_wr(2'd2, 16'h0002);

        // R3: direction 1 blocks the start
        bus_wr(2'd0, 16'h0303);
        bus_wr(2'd3, 16'h4444);
        idle(20);
        bus_wr(2'd0, 16'h0301);
        wait_end();
        bus_wr(2'd2, 16'h0002);

        // R11: DMA channel 0 feeds three words
        bus_wr(2'd1, 16'h0203);
        bus_wr(2'd0, 16'h1300);
        bus_wr(2'd0, 16'h1301);
        for (int w = 0; w < 3; w++) begin
            for (int i = 0; i < 500; i++) begin
                @(posedge clk); #1;
                if (dma_req[0]) break;
            end
            #1 reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h1111 * (w + 3);
            @(posedge clk); #2 reg_wr = 1'b0; reg_addr = 2'd2;
        end
        wait_end();
        bus_wr(2'd2, 16'h0002);
        bus_wr(2'd0, 16'h0004);   // R4 negate select
        idle(4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule